// File: doc/BRIEF.md
# Programmable Clock Output Generator

This block derives one programmable output clock from a set of candidate sources. Every source reaches it as a one-cycle tick enable in the single system clock domain. A configuration register picks the source and a 3-bit prescaler. The block emits a divided tick pulse and a toggling square output, both built from the selected source's ticks. A ready status bit goes high once the first divided tick has been produced.

Two build-time parameters fix the variant. The first chooses how the prescaler is read: as a shift, dividing by 2^PRES, or directly, dividing by PRES+1. The second chooses a narrow or a wide register layout. An optional master-select bit makes one extra source reachable beyond the select field. The configuration can only change while the output is gated off, so a running output never sees a source or divisor change in mid-period.

Top module: `progclk_gen`

## Requirements
- R1: During and after reset, before any write, rd_data_o, tick_o, clk_o, ready_o and status_o are all zero.
- R2: Register layout. Narrow layout: select in bits [1:0] and prescaler in bits [4:2]. Wide layout: select in bits [2:0] and prescaler in bits [6:4]. When HAS_MSEL is set, the master-select bit is bit 7. rd_data_o returns the stored fields at these positions, and every other bit reads zero. This includes bit 7 when HAS_MSEL is clear.
- R3: With DIRECT_DIV=0, tick_o gives one single-cycle pulse for every 2^PRES ticks of the selected source. Counting starts at zero on enable, so the first pulse follows the 2^PRES-th tick. The pulse appears one clock after the edge that takes that tick.
- R4: With DIRECT_DIV=1, tick_o pulses once every PRES+1 selected ticks, and all PRES values 0 to 7 are legal.
- R5: With DIRECT_DIV=0, a write whose prescaler field is 7 leaves the stored prescaler unchanged. The same write still updates the select and master-select fields.
- R6: With the master-select bit set and the select field zero, the source used is index 2^SEL_W, which is 4 in the narrow layout. With the master-select bit set and a non-zero select, the source used is the select value. With the master-select bit clear, the source used is the select value.
- R7: A write accepted while en_i is high leaves every stored field unchanged.
- R8: ready_o rises in the same cycle as the first tick_o pulse after enable and stays high while enabled. status_o carries ready_o at bit INST_ID+8, and all other status bits are zero.
- R9: In any cycle where en_i is low, ready_o, tick_o, clk_o and status_o are zero in that same cycle. The divide counter restarts from zero at the next enable.
- R10: clk_o starts low on enable and inverts with each tick_o pulse. Its level therefore equals the parity of the number of pulses since enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_i | input | 1 | Output enable; the configuration can be written only while this is low |
| src_tick_i | input | NSRC | One tick enable per candidate source |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_data_i | input | 16 | Configuration write data |
| rd_data_o | output | 16 | Active configuration fields at their layout positions |
| tick_o | output | 1 | Single-cycle divided tick |
| clk_o | output | 1 | Square output, toggled on each divided tick |
| ready_o | output | 1 | High once the first divided tick has been produced since enable |
| status_o | output | 16 | ready_o placed at bit INST_ID+8 |

## Verification
Every source ticks at its own period, so a wrong source pick shows up as a wrong pulse count. Two variants are swept over every select, master-select and prescaler combination: narrow shift mode with the master bit, and wide direct mode without it. The pulse counts separate shift division from N+1 division and catch an off-by-one terminal count. Each sweep also checks ready and square-wave parity cycle by cycle. Write data padded with ones in unused bits checks the field masking. Separate write sequences check the illegal shift value and writes made while enabled, and sampling right after en_i drops checks the same-cycle gating.

// File: rtl/progclk_pkg.sv
package progclk_pkg;
  localparam int REG_W     = 16;
  localparam int PRES_W    = 3;
  localparam int SELMAX_W  = 3;
  localparam int MSEL_BIT  = 7;
  localparam int STAT_BASE = 8;

  typedef struct packed {
    logic                msel;
    logic [SELMAX_W-1:0] sel;
    logic [PRES_W-1:0]   pres;
  } cfg_t;

  function automatic int sel_width(input bit wide);
    return wide ? 3 : 2;
  endfunction

  function automatic int pres_lsb(input bit wide);
    return wide ? 4 : 2;
  endfunction
endpackage

// File: rtl/progclk_rstsync.sv
module progclk_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/progclk_cfg.sv
module progclk_cfg
  import progclk_pkg::*;
#(
  parameter bit WIDE     = 1'b0,
  parameter bit DIRECT   = 1'b0,
  parameter bit HAS_MSEL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output cfg_t             cfg_o,
  output logic [REG_W-1:0] rd_data_o
);
  localparam int SEL_W    = sel_width(WIDE);
  localparam int PLSB     = pres_lsb(WIDE);
  localparam int PRES_MAX = (1 << PRES_W) - 1;

  logic [SELMAX_W-1:0] sel_new;
  logic [PRES_W-1:0]   pres_new;
  logic                msel_new;
  logic                accept;
  logic                pres_ok;
  cfg_t                cfg_q;
  cfg_t                cfg_d;

  always_comb begin
    sel_new              = '0;
    sel_new[SEL_W-1:0]   = wr_data_i[SEL_W-1:0];
    pres_new             = wr_data_i[PLSB +: PRES_W];
    msel_new             = HAS_MSEL ? wr_data_i[MSEL_BIT] : 1'b0;
    pres_ok              = DIRECT || (pres_new != PRES_W'(PRES_MAX));
    accept               = wr_en_i && !en_i;
    cfg_d                = cfg_q;
    cfg_d.sel            = sel_new;
    cfg_d.msel           = msel_new;
    if (pres_ok) cfg_d.pres = pres_new;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (accept) cfg_q <= cfg_d;
  end

  always_comb begin
    rd_data_o                  = '0;
    rd_data_o[SEL_W-1:0]       = cfg_q.sel[SEL_W-1:0];
    rd_data_o[PLSB +: PRES_W]  = cfg_q.pres;
    rd_data_o[MSEL_BIT]        = cfg_q.msel;
  end

  assign cfg_o = cfg_q;

  assert_hold_while_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |=> $stable(cfg_q));

  assert_bad_shift_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!DIRECT && wr_en_i && !en_i && wr_data_i[PLSB +: PRES_W] == PRES_W'(PRES_MAX))
      |=> cfg_q.pres == $past(cfg_q.pres));
endmodule

// File: rtl/progclk_srcsel.sv
module progclk_srcsel
  import progclk_pkg::*;
#(
  parameter bit WIDE = 1'b0,
  parameter int NSRC = 5
) (
  input  cfg_t            cfg_i,
  input  logic [NSRC-1:0] src_tick_i,
  output logic            tick_o
);
  localparam int SEL_W = sel_width(WIDE);
  localparam int EXTRA = 1 << SEL_W;

  logic [3:0]      idx;
  logic [NSRC-1:0] hit;

  always_comb begin
    if (cfg_i.msel && cfg_i.sel == '0) idx = 4'(EXTRA);
    else                               idx = {1'b0, cfg_i.sel};
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_hit
    assign hit[i] = src_tick_i[i] && (idx == 4'(i));
  end

  assign tick_o = |hit;
endmodule

// File: rtl/progclk_div.sv
module progclk_div
  import progclk_pkg::*;
#(
  parameter bit DIRECT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic [PRES_W-1:0] pres_i,
  output logic              fire_o,
  output logic              clk_o,
  output logic              rdy_o
);
  localparam int CNT_W = DIRECT ? PRES_W : (1 << PRES_W) - 1;

  logic [CNT_W-1:0] term;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             hit;
  logic             fire_q, fire_d;
  logic             clk_q, clk_d;
  logic             rdy_q, rdy_d;

  if (DIRECT) begin : g_direct
    assign term = CNT_W'(pres_i);
  end else begin : g_shift
    assign term = (CNT_W'(1) << pres_i) - CNT_W'(1);
  end

  always_comb begin
    hit    = tick_i && (cnt_q == term);
    cnt_d  = cnt_q;
    if (!en_i)       cnt_d = '0;
    else if (tick_i) cnt_d = hit ? '0 : cnt_q + CNT_W'(1);
    fire_d = en_i && hit;
    clk_d  = en_i && (fire_d ? !clk_q : clk_q);
    rdy_d  = en_i && (rdy_q || fire_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (!en_i || tick_i)   cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fire_q <= 1'b0;
      clk_q  <= 1'b0;
      rdy_q  <= 1'b0;
    end else begin
      fire_q <= fire_d;
      clk_q  <= clk_d;
      rdy_q  <= rdy_d;
    end
  end

  assign fire_o = fire_q;
  assign clk_o  = clk_q;
  assign rdy_o  = rdy_q;

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= term);

  assert_idle_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (cnt_q == '0 && !rdy_q && !clk_q && !fire_q));

  assert_ready_with_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_q) |-> fire_q);

  assert_toggle_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && $past(en_i) && !fire_q) |=> (fire_q ? clk_q != $past(clk_q) : clk_q == $past(clk_q)));
endmodule

// File: rtl/progclk_gen.sv
module progclk_gen
  import progclk_pkg::*;
#(
  parameter bit DIRECT_DIV  = 1'b0,
  parameter bit WIDE_LAYOUT = 1'b0,
  parameter bit HAS_MSEL    = 1'b1,
  parameter int INST_ID     = 0,
  localparam int NSRC       = (1 << sel_width(WIDE_LAYOUT)) + (HAS_MSEL ? 1 : 0)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [NSRC-1:0]  src_tick_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             tick_o,
  output logic             clk_o,
  output logic             ready_o,
  output logic [REG_W-1:0] status_o
);
  logic rst_sync_n;
  cfg_t cfg;
  logic sel_tick;
  logic fire, clk_div, rdy;

  progclk_rstsync u_rstsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  progclk_cfg #(
    .WIDE     (WIDE_LAYOUT),
    .DIRECT   (DIRECT_DIV),
    .HAS_MSEL (HAS_MSEL)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .en_i      (en_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .cfg_o     (cfg),
    .rd_data_o (rd_data_o)
  );

  progclk_srcsel #(
    .WIDE (WIDE_LAYOUT),
    .NSRC (NSRC)
  ) u_srcsel (
    .cfg_i      (cfg),
    .src_tick_i (src_tick_i),
    .tick_o     (sel_tick)
  );

  progclk_div #(
    .DIRECT (DIRECT_DIV)
  ) u_div (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .en_i   (en_i),
    .tick_i (sel_tick),
    .pres_i (cfg.pres),
    .fire_o (fire),
    .clk_o  (clk_div),
    .rdy_o  (rdy)
  );

  assign tick_o  = fire && en_i;
  assign clk_o   = clk_div && en_i;
  assign ready_o = rdy && en_i;

  always_comb begin
    status_o                     = '0;
    status_o[STAT_BASE + INST_ID] = ready_o;
  end
endmodule

// File: tb/progclk_gen_bench.sv
`timescale 1ns/1ps
module progclk_gen_bench;
  logic clk = 1'b0;
  logic rst_n;
  always #2.5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  logic [7:0] srcv;

  logic en_a, wr_a, tk_a, ck_a, ry_a;
  logic [15:0] wd_a, rd_a, st_a;
  logic en_b, wr_b, tk_b, ck_b, ry_b;
  logic [15:0] wd_b, rd_b, st_b;

  progclk_gen #(.DIRECT_DIV(1'b0), .WIDE_LAYOUT(1'b0), .HAS_MSEL(1'b1), .INST_ID(3)) u_progclk_gen (
    .clk(clk), .rst_n(rst_n), .en_i(en_a), .src_tick_i(srcv[4:0]), .wr_en_i(wr_a),
    .wr_data_i(wd_a), .rd_data_o(rd_a), .tick_o(tk_a), .clk_o(ck_a), .ready_o(ry_a),
    .status_o(st_a));

  progclk_gen #(.DIRECT_DIV(1'b1), .WIDE_LAYOUT(1'b1), .HAS_MSEL(1'b0), .INST_ID(6)) u_progclk_gen_b (
    .clk(clk), .rst_n(rst_n), .en_i(en_b), .src_tick_i(srcv), .wr_en_i(wr_b),
    .wr_data_i(wd_b), .rd_data_o(rd_b), .tick_o(tk_b), .clk_o(ck_b), .ready_o(ry_b),
    .status_o(st_b));

  function automatic logic [7:0] pat(input int c);
    logic [7:0] p;
    for (int i = 0; i < 8; i++) p[i] = ((c % (i + 2)) == 0);
    return p;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic wr(input bit b, input logic [15:0] d);
    if (b) begin wr_b = 1'b1; wd_b = d; end
    else   begin wr_a = 1'b1; wd_a = d; end
    @(negedge clk);
    wr_a = 1'b0;
    wr_b = 1'b0;
  endtask

  task automatic run_case(input bit b, input int sel, input int msel, input int pres, input int win);
    int src, dv, nsel, pulses;
    bit ok_seq;
    logic [15:0] d, expd;
    logic t, c, r;
    string tag;
    if (!b) begin
      d    = 16'hFF60 | 16'((msel << 7) | (pres << 2) | sel);
      expd = 16'((msel << 7) | (pres << 2) | sel);
      src  = (msel != 0 && sel == 0) ? 4 : sel;
      dv   = 1 << pres;
      tag  = (msel != 0) ? "R3 R6" : "R3";
    end else begin
      d    = 16'hFF88 | 16'((pres << 4) | sel);
      expd = 16'((pres << 4) | sel);
      src  = sel;
      dv   = pres + 1;
      tag  = "R4";
    end
    wr(b, d);
    check((b ? rd_b : rd_a) == expd, "R2 readback", int'(b ? rd_b : rd_a), int'(expd));
    if (b) en_b = 1'b1; else en_a = 1'b1;
    nsel = 0; pulses = 0; ok_seq = 1'b1;
    for (int k = 0; k < win + 2; k++) begin
      t = b ? tk_b : tk_a;
      c = b ? ck_b : ck_a;
      r = b ? ry_b : ry_a;
      if (t) pulses++;
      if (r != (pulses > 0) || c != pulses[0]) ok_seq = 1'b0;
      srcv = (k < win) ? pat(cyc) : 8'h00;
      if (srcv[src]) nsel++;
      cyc++;
      @(negedge clk);
    end
    check(pulses == nsel / dv, tag, pulses, nsel / dv);
    check(ok_seq, "R8 R10 ready/parity sequence", int'(ok_seq), 1);
    if (pulses > 0)
      check((b ? st_b : st_a) == (b ? 16'h4000 : 16'h0800), "R8 status bit",
            int'(b ? st_b : st_a), int'(b ? 16'h4000 : 16'h0800));
    if (b) en_b = 1'b0; else en_a = 1'b0;
    #1;
    check(!(b ? (ry_b | ck_b | tk_b) : (ry_a | ck_a | tk_a)), "R9 gated outputs",
          int'(b ? {ry_b, ck_b, tk_b} : {ry_a, ck_a, tk_a}), 0);
    check((b ? st_b : st_a) == 16'h0, "R9 status", int'(b ? st_b : st_a), 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    en_a = 0; wr_a = 0; wd_a = '0;
    en_b = 0; wr_b = 0; wd_b = '0;
    srcv = '0;
    repeat (3) @(negedge clk);
    check(rd_a == 0 && st_a == 0 && !tk_a && !ck_a && !ry_a, "R1 reset A", int'(rd_a), 0);
    check(rd_b == 0 && st_b == 0 && !tk_b && !ck_b && !ry_b, "R1 reset B", int'(rd_b), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(rd_a == 0 && st_a == 0, "R1 after release A", int'(rd_a), 0);
    check(rd_b == 0 && st_b == 0, "R1 after release B", int'(rd_b), 0);

    for (int s = 0; s < 4; s++)
      for (int m = 0; m < 2; m++)
        for (int p = 0; p < 7; p++)
          run_case(1'b0, s, m, p, 400);

    for (int s = 0; s < 8; s++)
      for (int p = 0; p < 8; p++)
        run_case(1'b1, s, 0, p, 120);

    // R5: shift value 7 rejected, select still written
    wr(1'b0, 16'h000D);
    wr(1'b0, 16'h001E);
    check(rd_a == 16'h000E, "R5 prescaler kept", int'(rd_a), 16'h000E);

    // R7: writes while enabled are dropped
    wr(1'b0, 16'h008D);
    en_a = 1'b1;
    @(negedge clk);
    wr(1'b0, 16'h0012);
    check(rd_a == 16'h008D, "R7 write while enabled A", int'(rd_a), 16'h008D);
    en_a = 1'b0;
    @(negedge clk);
    wr(1'b1, 16'h0035);
    en_b = 1'b1;
    @(negedge clk);
    wr(1'b1, 16'h0071);
    check(rd_b == 16'h0035, "R7 write while enabled B", int'(rd_b), 16'h0035);
    en_b = 1'b0;
    @(negedge clk);

    summary();
    $finish;
  end
endmodule